// File: doc/BRIEF.md
# Interleaved Strided Vector Load Unit

This block answers vector load requests from a memory that is spread word by word across a set of interleaved banks. A request names a base word address, a number of elements and an addressing mode: consecutive words, a fixed step between elements, or a gather in which each element adds its own offset to the base. Once a request is accepted, the block forms one element address per cycle. It picks the bank from the low address bits and starts the read when that bank is free. When the bank is still busy with an earlier read, it holds the element back and counts one stall cycle.

Each bank is modelled as a small register array that cannot overlap reads. After it starts a read, it stays busy for a fixed number of cycles, and the word appears at the output that many cycles after issue. All banks share the same latency and elements issue in order, so results leave in element order without a reorder buffer. Each result carries its element index. A one-cycle done pulse follows the last result, and the block takes the next request only after that. Throughput therefore depends on the stride, and on how the bank count compares with the bank latency.

Top module: `strided_vec_load`

## Requirements
- R1: During and straight after reset, reqReady is 1, rspValid is 0, done is 0 and stallCount is 0.
- R2: Word address a lives in bank a mod NUM_BANKS, at row a / NUM_BANKS. Once a bank starts a read in cycle t, it starts no other read before cycle t+BANK_LAT.
- R3: Reset loads every bank word at address a with the value (a*37 + 11) mod 2^DATA_W. A returned element carries the value of its word.
- R4: reqMode selects the element address for element i. 0 (and the unused code 3) gives base+i. 1 gives base+i*reqStride. 2 gives base+off(i), where off(i) is reqOffsets[i*ADDR_W +: ADDR_W]. Every address wraps modulo NUM_BANKS*BANK_WORDS.
- R5: An element whose bank is still busy waits. Each cycle in which an element waits adds 1 to stallCount. stallCount returns to 0 when a request is accepted and holds its final value after done.
- R6: A request accepted in cycle a can issue element 0 in cycle a+1, and the element issued in cycle t appears on rspValid in cycle t+BANK_LAT. Unit stride with BANK_LAT <= NUM_BANKS never stalls. With BANK_LAT > NUM_BANKS it leaves gaps.
- R7: Results come out strictly in element order, and rspIdx carries the element number 0, 1, 2 and so on.
- R8: A request is taken in a cycle where reqValid and reqReady are both 1. reqReady is 0 from the next cycle until the done cycle. Request inputs that change while the block is running have no effect on the running request.
- R9: done is a single-cycle pulse in the cycle after the last element. reqReady is 1 in that same cycle.
- R10: A request of length L, with 1 <= L <= MAX_VL, returns exactly L elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqMode | input | 2 | Addressing mode: 0 unit, 1 stride, 2 gather |
| reqBase | input | ADDR_W | Base word address |
| reqLen | input | LEN_W | Element count, 1 to MAX_VL |
| reqStride | input | ADDR_W | Step between elements in stride mode |
| reqOffsets | input | MAX_VL*ADDR_W | Gather offsets, element i in slice i |
| rspValid | output | 1 | Result element present |
| rspIdx | output | IDX_W | Element number of the result |
| rspData | output | DATA_W | Element value |
| done | output | 1 | Pulse after the last element |
| stallCount | output | STALL_W | Bank-conflict stall cycles of the current request |

## Verification
The bench builds two copies of the block, each with 8 banks of 16 words. One copy has a bank latency of 4 and the other a latency of 10. With latency 4, unit stride and odd strides run with no stall, while strides of 4 and same-bank gathers give known conflict counts. With latency 10 the bank count is below the latency, so even unit stride shows the gap pattern, and every mode is checked under heavy bank reuse, with wrapping addresses, single-element requests and a request held during a run.

// File: rtl/svl_pkg.sv
package svl_pkg;

  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_GATHER = 2'd2,
    MODE_RSVD   = 2'd3
  } accessMode_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic capture;  // latch a new request
    logic issue;    // start the current element in its bank
  } ctrlStrobes_t;

  // Initial bank contents as a function of the word address (R3).
  function automatic logic [31:0] fillWord(input logic [31:0] addr);
    return addr * 32'd37 + 32'd11;
  endfunction

endpackage

// File: rtl/svl_bank.sv
module svl_bank
  import svl_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_WORDS = 16,
  parameter int BANK_LAT   = 4,
  parameter int DATA_W     = 16,
  parameter int BANK_ID    = 0,
  localparam int ROW_W = $clog2(BANK_WORDS),
  localparam int CNT_W = $clog2(BANK_LAT + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ROW_W-1:0]  rdRow,
  output logic              busy,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] cells [BANK_WORDS];
  logic [CNT_W-1:0]  busyCnt;

  // Contents are loaded at reset only; there is no write path.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < BANK_WORDS; r++) begin
        cells[r] <= DATA_W'(fillWord(32'(r * NUM_BANKS + BANK_ID)));
      end
    end
  end

  // Unpipelined: busy for BANK_LAT-1 cycles after the start cycle (R2).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (start) begin
      busyCnt <= CNT_W'(BANK_LAT - 1);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy   = (busyCnt != '0);
  assign rdData = cells[rdRow];

  // R2: the issue logic never starts a bank that is still busy.
  a_r2_no_start_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busy);

endmodule

// File: rtl/svl_datapath.sv
module svl_datapath
  import svl_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_WORDS = 16,
  parameter int BANK_LAT   = 4,
  parameter int DATA_W     = 16,
  parameter int MAX_VL     = 64,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = $clog2(NUM_BANKS * BANK_WORDS),
  localparam int ROW_W  = ADDR_W - BANK_W,
  localparam int IDX_W  = $clog2(MAX_VL),
  localparam int LEN_W  = $clog2(MAX_VL + 1)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [1:0]               reqMode,
  input  logic [ADDR_W-1:0]        reqBase,
  input  logic [LEN_W-1:0]         reqLen,
  input  logic [ADDR_W-1:0]        reqStride,
  input  logic [MAX_VL*ADDR_W-1:0] reqOffsets,
  output logic                     issuePending,
  output logic                     tgtBusy,
  output logic                     retValid,
  output logic                     retLast,
  output logic [IDX_W-1:0]         rspIdx,
  output logic [DATA_W-1:0]        rspData
);

  // Captured request
  accessMode_e       modeQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] stepQ;
  logic [LEN_W-1:0]  lenQ;
  logic [ADDR_W-1:0] offQ [MAX_VL];

  // Issue state
  logic [LEN_W-1:0]  issCnt;
  logic [ADDR_W-1:0] runAddr;
  logic [IDX_W-1:0]  issIdx;
  logic [ADDR_W-1:0] tgtAddr;
  logic [BANK_W-1:0] tgtBank;

  // Return delay line, one stage per cycle of bank latency
  logic              pV    [BANK_LAT];
  logic [IDX_W-1:0]  pIdx  [BANK_LAT];
  logic [ADDR_W-1:0] pAddr [BANK_LAT];

  logic [NUM_BANKS-1:0] bankBusy;
  logic [DATA_W-1:0]    bankData [NUM_BANKS];
  logic [ROW_W-1:0]     outRow;
  logic [BANK_W-1:0]    outBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_UNIT;
      baseQ   <= '0;
      stepQ   <= '0;
      lenQ    <= '0;
      issCnt  <= '0;
      runAddr <= '0;
      for (int i = 0; i < MAX_VL; i++) offQ[i] <= '0;
    end else if (strobes.capture) begin
      modeQ   <= accessMode_e'(reqMode);
      baseQ   <= reqBase;
      // R4: unit stride (and the spare code) steps by one word
      stepQ   <= (accessMode_e'(reqMode) == MODE_STRIDE) ? reqStride : ADDR_W'(1);
      lenQ    <= reqLen;
      issCnt  <= '0;
      runAddr <= reqBase;
      for (int i = 0; i < MAX_VL; i++) offQ[i] <= reqOffsets[i*ADDR_W +: ADDR_W];
    end else if (strobes.issue) begin
      issCnt  <= issCnt + 1'b1;
      runAddr <= runAddr + stepQ;   // wraps modulo memory size (R4)
    end
  end

  assign issIdx       = issCnt[IDX_W-1:0];
  assign tgtAddr      = (modeQ == MODE_GATHER) ? (baseQ + offQ[issIdx]) : runAddr;
  assign tgtBank      = tgtAddr[BANK_W-1:0];          // R2 bank select
  assign issuePending = (issCnt < lenQ);
  assign tgtBusy      = bankBusy[tgtBank];

  // Bank array
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    svl_bank #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_WORDS(BANK_WORDS),
      .BANK_LAT  (BANK_LAT),
      .DATA_W    (DATA_W),
      .BANK_ID   (b)
    ) u_bank (
      .clk   (clk),
      .rstN  (rstN),
      .start (strobes.issue && (tgtBank == BANK_W'(b))),
      .rdRow (outRow),
      .busy  (bankBusy[b]),
      .rdData(bankData[b])
    );
  end

  // R6: an element issued in cycle t is presented in cycle t+BANK_LAT
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < BANK_LAT; k++) begin
        pV[k]    <= 1'b0;
        pIdx[k]  <= '0;
        pAddr[k] <= '0;
      end
    end else begin
      pV[0]    <= strobes.issue;
      pIdx[0]  <= issIdx;
      pAddr[0] <= tgtAddr;
      for (int k = 1; k < BANK_LAT; k++) begin
        pV[k]    <= pV[k-1];
        pIdx[k]  <= pIdx[k-1];
        pAddr[k] <= pAddr[k-1];
      end
    end
  end

  assign outRow   = pAddr[BANK_LAT-1][ADDR_W-1:BANK_W];
  assign outBank  = pAddr[BANK_LAT-1][BANK_W-1:0];
  assign retValid = pV[BANK_LAT-1];
  assign rspIdx   = pIdx[BANK_LAT-1];
  assign rspData  = bankData[outBank];
  assign retLast  = retValid && (LEN_W'(pIdx[BANK_LAT-1]) == lenQ - LEN_W'(1));

  // R7: back-to-back results carry consecutive element numbers
  a_r7_in_order: assert property (@(posedge clk) disable iff (!rstN)
    retValid && $past(retValid) |-> rspIdx == $past(rspIdx) + 1'b1);

endmodule

// File: rtl/svl_ctrl.sv
module svl_ctrl
  import svl_pkg::*;
#(
  parameter int STALL_W = 12
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               issuePending,
  input  logic               tgtBusy,
  input  logic               retValid,
  input  logic               retLast,
  output logic               reqReady,
  output logic               done,
  output logic [STALL_W-1:0] stallCount,
  output ctrlStrobes_t       strobes
);

  typedef enum logic {ST_IDLE, ST_RUN} runState_e;

  runState_e state;
  logic      stallNow;
  logic      finishNow;

  assign reqReady        = (state == ST_IDLE);
  assign strobes.capture = reqReady && reqValid;
  assign strobes.issue   = (state == ST_RUN) && issuePending && !tgtBusy;
  assign stallNow        = (state == ST_RUN) && issuePending && tgtBusy;
  assign finishNow       = (state == ST_RUN) && retValid && retLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      stallCount <= '0;
    end else begin
      done <= finishNow;                       // R9
      if (strobes.capture) begin
        state      <= ST_RUN;
        stallCount <= '0;                      // R5 clear per request
      end else begin
        if (finishNow) state <= ST_IDLE;
        if (stallNow)  stallCount <= stallCount + 1'b1;
      end
    end
  end

  // R8: once a request is taken, the block is not ready next cycle
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !reqReady);

  // R9: the done pulse coincides with readiness for the next request
  a_r9_done_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R9: no result is returned while idle
  a_r9_no_result_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    retValid |-> !reqReady);

  // R5: the stall counter only advances after a bank-conflict cycle
  a_r5_stall_only_on_conflict: assert property (@(posedge clk) disable iff (!rstN)
    (stallCount != $past(stallCount)) && !$past(strobes.capture) |-> $past(tgtBusy));

endmodule

// File: rtl/strided_vec_load.sv
module strided_vec_load
  import svl_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_WORDS = 16,
  parameter int BANK_LAT   = 4,
  parameter int DATA_W     = 16,
  parameter int MAX_VL     = 64,
  parameter int STALL_W    = 12,
  localparam int ADDR_W = $clog2(NUM_BANKS * BANK_WORDS),
  localparam int IDX_W  = $clog2(MAX_VL),
  localparam int LEN_W  = $clog2(MAX_VL + 1)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [1:0]               reqMode,
  input  logic [ADDR_W-1:0]        reqBase,
  input  logic [LEN_W-1:0]         reqLen,
  input  logic [ADDR_W-1:0]        reqStride,
  input  logic [MAX_VL*ADDR_W-1:0] reqOffsets,
  output logic                     rspValid,
  output logic [IDX_W-1:0]         rspIdx,
  output logic [DATA_W-1:0]        rspData,
  output logic                     done,
  output logic [STALL_W-1:0]       stallCount
);

  ctrlStrobes_t strobes;
  logic issuePending;
  logic tgtBusy;
  logic retValid;
  logic retLast;

  svl_ctrl #(
    .STALL_W(STALL_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .issuePending(issuePending),
    .tgtBusy     (tgtBusy),
    .retValid    (retValid),
    .retLast     (retLast),
    .reqReady    (reqReady),
    .done        (done),
    .stallCount  (stallCount),
    .strobes     (strobes)
  );

  svl_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_WORDS(BANK_WORDS),
    .BANK_LAT  (BANK_LAT),
    .DATA_W    (DATA_W),
    .MAX_VL    (MAX_VL)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqMode     (reqMode),
    .reqBase     (reqBase),
    .reqLen      (reqLen),
    .reqStride   (reqStride),
    .reqOffsets  (reqOffsets),
    .issuePending(issuePending),
    .tgtBusy     (tgtBusy),
    .retValid    (retValid),
    .retLast     (retLast),
    .rspIdx      (rspIdx),
    .rspData     (rspData)
  );

  assign rspValid = retValid;

endmodule

// File: tb/test_strided_vec_load.sv
module svl_harness #(
  parameter int LAT = 4
)(
  input  logic clk,
  output logic finished,
  output int   errCount,
  output int   checkCount
);
  localparam int NB  = 8;
  localparam int WPB = 16;
  localparam int TOT = NB * WPB;
  localparam int AW  = 7;
  localparam int DW  = 16;
  localparam int MVL = 64;
  localparam int IW  = 6;
  localparam int LW  = 7;
  localparam int SW  = 12;

  logic          rstN;
  logic          reqValid;
  logic          reqReady;
  logic [1:0]    reqMode;
  logic [AW-1:0] reqBase;
  logic [LW-1:0] reqLen;
  logic [AW-1:0] reqStride;
  logic [MVL*AW-1:0] reqOffsets;
  logic          rspValid;
  logic [IW-1:0] rspIdx;
  logic [DW-1:0] rspData;
  logic          done;
  logic [SW-1:0] stallCount;

  int dirStall;   // expected stall total for the running request, -1 = none

  strided_vec_load #(
    .NUM_BANKS(NB), .BANK_WORDS(WPB), .BANK_LAT(LAT),
    .DATA_W(DW), .MAX_VL(MVL), .STALL_W(SW)
  ) i_strided_vec_load (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqBase(reqBase), .reqLen(reqLen),
    .reqStride(reqStride), .reqOffsets(reqOffsets),
    .rspValid(rspValid), .rspIdx(rspIdx), .rspData(rspData),
    .done(done), .stallCount(stallCount)
  );

  function automatic int wordVal(input int a);
    return (a * 37 + 11) % (1 << DW);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s (latency %0d): actual=%0d expected=%0d", tag, LAT, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int due; int idx; int addr; } pend_t;
  pend_t mq[$];
  int cyc = 0;
  int mIdle, mLen, mMode, mBase, mStride, mNext, mStall, mDoneAt, mSeen;
  int offs [MVL];
  int bankFree [NB];

  function automatic int addrOf(input int i);
    if (mMode == 2)      return (mBase + offs[i]) % TOT;
    else if (mMode == 1) return (mBase + i * mStride) % TOT;
    else                 return (mBase + i) % TOT;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      mq.delete();
      mIdle = 1; mLen = 0; mNext = 0; mStall = 0; mDoneAt = -1; mSeen = 0;
      for (int b = 0; b < NB; b++) bankFree[b] = -1000;
      check(reqReady == 1'b1, "R1 reqReady in reset", reqReady, 1);
      check(rspValid == 1'b0, "R1 rspValid in reset", rspValid, 0);
      check(done == 1'b0, "R1 done in reset", done, 0);
      check(stallCount == '0, "R1 stallCount in reset", stallCount, 0);
    end else begin
      bit expValid;
      expValid = (mq.size() > 0) && (mq[0].due == cyc);
      check(reqReady == 1'(mIdle), "R8 reqReady", reqReady, mIdle);
      check(rspValid == expValid, "R6 rspValid timing", rspValid, expValid);
      if (expValid && rspValid) begin
        check(rspIdx == IW'(mq[0].idx), "R7 element index", rspIdx, mq[0].idx);
        check(rspData == DW'(wordVal(mq[0].addr)), "R3 element data", rspData,
              wordVal(mq[0].addr));
      end
      check(done == (mDoneAt == cyc), "R9 done pulse", done, (mDoneAt == cyc));
      check(stallCount == SW'(mStall), "R5 stall count", stallCount, mStall);
      if (done && mDoneAt == cyc) begin
        check(mSeen == mLen, "R10 element count", mSeen, mLen);
        if (dirStall >= 0)
          check(stallCount == SW'(dirStall), "R5 conflict total", stallCount, dirStall);
      end
      // advance the model with the inputs of this cycle
      if (mIdle != 0) begin
        if (reqValid) begin
          mLen = int'(reqLen); mMode = int'(reqMode); mBase = int'(reqBase);
          mStride = int'(reqStride);
          for (int i = 0; i < MVL; i++) offs[i] = int'(reqOffsets[i*AW +: AW]);
          mNext = 0; mStall = 0; mSeen = 0; mIdle = 0;
        end
      end else if (mNext < mLen) begin
        int a, b;
        a = addrOf(mNext);
        b = a % NB;
        if (bankFree[b] <= cyc) begin
          mq.push_back('{cyc + LAT, mNext, a});
          bankFree[b] = cyc + LAT;
          mNext++;
        end else begin
          mStall++;
        end
      end
      if (expValid) begin
        mSeen++;
        if (mq[0].idx == mLen - 1) begin
          mDoneAt = cyc + 1;
          mIdle = 1;
        end
        void'(mq.pop_front());
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic int offVal(input int kind, input int i);
    case (kind)
      1:       return (i * 5) % TOT;
      2:       return (i * NB) % TOT;
      3:       return (i * i * 3 + 1) % TOT;
      default: return 0;
    endcase
  endfunction

  task automatic setReq(input int mode, input int base, input int len, input int stride,
                        input int kind);
    reqMode   = 2'(mode);
    reqBase   = AW'(base);
    reqLen    = LW'(len);
    reqStride = AW'(stride);
    for (int i = 0; i < MVL; i++) reqOffsets[i*AW +: AW] = AW'(offVal(kind, i));
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  task automatic runReq(input int mode, input int base, input int len, input int stride,
                        input int kind, input int expStall);
    @(posedge clk); #1;
    setReq(mode, base, len, stride, kind);
    dirStall = expStall;
    reqValid = 1'b1;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    reqValid = 1'b0;
    // R8: disturb the request inputs while running
    setReq(2, base ^ 85, 1, stride + 3, 3);
    waitDone();
  endtask

  initial begin
    finished = 1'b0;
    rstN = 1'b0;
    reqValid = 1'b0;
    dirStall = -1;
    setReq(0, 0, 1, 0, 0);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R6: unit stride over the full length; gaps only when latency exceeds bank count
    runReq(0, 0, 64, 1, 0, (LAT <= NB) ? 0 : 14);
    // R5: stride 4 touches two banks only
    runReq(1, 1, 8, 4, 0, (LAT == 4) ? 6 : 24);
    // R5: stride 3 is relatively prime to the bank count
    runReq(1, 5, 16, 3, 0, (LAT == 4) ? 0 : 2);
    // R5: stride 2 touches four banks
    runReq(1, 0, 16, 2, 0, (LAT == 4) ? 0 : 18);
    // R4: gather with spread offsets
    runReq(2, 2, 20, 0, 1, -1);
    // R2: gather that hits one bank every time
    runReq(2, 7, 6, 0, 2, 5 * (LAT - 1));
    // R4: irregular gather with wrap-around
    runReq(2, 100, 33, 0, 3, -1);
    // R4: oversized stride wraps modulo memory size
    runReq(1, 120, 10, 100, 0, -1);
    // R10: single element at the top address
    runReq(0, TOT - 1, 1, 0, 0, 0);

    // R8: request held valid during a run is taken only at done
    @(posedge clk); #1;
    setReq(1, 9, 12, 7, 0);
    dirStall = -1;
    reqValid = 1'b1;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    setReq(3, 60, 5, 9, 0);
    waitDone();
    @(posedge clk); #1;
    reqValid = 1'b0;
    waitDone();

    repeat (4) @(posedge clk);
    finished = 1'b1;
  end
endmodule

module test_strided_vec_load;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic finFast, finSlow;
  int   errFast, errSlow, chkFast, chkSlow;

  svl_harness #(.LAT(4)) u_fast (
    .clk(clk), .finished(finFast), .errCount(errFast), .checkCount(chkFast));

  svl_harness #(.LAT(10)) u_slow (
    .clk(clk), .finished(finSlow), .errCount(errSlow), .checkCount(chkSlow));

  initial begin
    int waited = 0;
    int wdErr = 0;
    while (!(finFast === 1'b1 && finSlow === 1'b1) && waited < WATCHDOG_CYCLES) begin
      @(posedge clk);
      waited++;
    end
    if (!(finFast === 1'b1 && finSlow === 1'b1)) begin
      wdErr = 1;
      $display("FAIL watchdog R10: actual=%0d expected=%0d cycles", waited, WATCHDOG_CYCLES);
    end
    #1;
    $display("Result: errors=%0d of %0d checks", errFast + errSlow + wdErr,
             chkFast + chkSlow + 1);
    $finish;
  end
endmodule